// File: doc/BRIEF.md
# Partitioned-LRU Four-Way Read Cache

This block is a read-only, four-way set-associative cache. It sits between one bus requester and a slow backing memory. Every lookup is tagged as either an instruction fetch or a data reference. A hit returns the word in the same clock as the request. A miss raises a stall to the requester and sends a single request to the backing memory. When the memory answers, the word goes straight to the requester, and a victim way in the set may be filled with it. Each line holds one word. The low address bits select the set and the remaining bits form the tag.

A two-bit policy input sets where a miss may allocate. In the shared policy, any of the four ways can be replaced. In the split policies, a fixed group of ways serves instruction fetches and another group serves data references. The lookup still compares all four ways in every policy, so a line filled under one policy can hit under another. Caching can be turned off separately for each access type. A turned-off type always goes to memory, never allocates and never changes the recency state. An invalidate pulse drops every line at once. The policy and the enables are sampled when a miss starts and held internally until its fill ends.

Top module: `plru_rd_cache`

## Requirements
- R1: A request (`req_valid`=1) whose access type is enabled and whose tag is valid in any of the four ways of its set returns `rsp_valid`=1 with the stored word in the same cycle. In that cycle `stall`=0 and `mem_req`=0.
- R2: Any other request raises `mem_req` for exactly one cycle, with `mem_addr` equal to `req_addr`, and raises `stall` in that cycle. `stall` stays high until the cycle in which `mem_valid`=1. In that cycle `rsp_valid`=1, `rsp_data`=`mem_data` and `stall`=0. `rsp_valid` and `stall` are never high together.
- R3: With `mode`=0 (and also `mode`=3), a fill may use any of ways 0 to 3. The lowest-numbered invalid way is chosen first. If all four ways are valid, the least recently used way is chosen.
- R4: With `mode`=1, instruction misses (`req_is_data`=0) fill only ways 0 and 1, and data misses (`req_is_data`=1) fill only ways 2 and 3. Within the pair, an invalid way is chosen first (lower number first), otherwise the less recently used way.
- R5: With `mode`=2, instruction misses fill only ways 0 to 2, with an invalid way first and otherwise the LRU way among the three. Data misses always fill way 3.
- R6: The hit check compares all four ways regardless of `mode` and access type. Partitioning only restricts the choice of victim.
- R7: Every hit and every fill makes the accessed way the most recent in its set. The other ways keep their relative order. After reset the recency order of each set, from most to least recent, is way 0, 1, 2, 3.
- R8: When the enable for the request's type is low (`ifetch_en` for instructions, `data_en` for data), the request always goes to memory as in R2, even if the line is resident. Its fill allocates nothing and leaves the recency state unchanged.
- R9: After reset all lines are invalid, and `rsp_valid`, `stall` and `mem_req` are 0 while no request is presented.
- R10: A cycle with `inv`=1 makes every line invalid from the next cycle on. This includes a line being filled in that same cycle. A lookup in the `inv` cycle itself still sees the old contents.
- R11: The policy and the allocation decision of a miss are taken from `mode`, `ifetch_en` and `data_en` in the cycle the miss starts. Changes to these inputs while the fill is outstanding do not affect that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held with a stable address and type until `rsp_valid` |
| req_addr | input | ADDR_W | Word address; low bits select the set |
| req_is_data | input | 1 | 1 for a data reference, 0 for an instruction fetch |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_data | output | DATA_W | Response word |
| stall | output | 1 | Request presented but not yet answered |
| mode | input | 2 | Replacement policy: 0 shared, 1 two-and-two, 2 three-and-one, 3 shared |
| ifetch_en | input | 1 | Caching enable for instruction fetches |
| data_en | input | 1 | Caching enable for data references |
| inv | input | 1 | Invalidate every line |
| mem_req | output | 1 | One-cycle request to the backing memory |
| mem_addr | output | ADDR_W | Address of the memory request |
| mem_valid | input | 1 | Memory word valid, a fixed MEM_LAT cycles after `mem_req` |
| mem_data | input | DATA_W | Memory word |

## Verification
The bench keeps its own model of the cache: a recency list per set and a validity and tag table. It compares that model with the ports every clock while it drives full sets under each policy until they evict. The split policies are the focus. A victim chosen outside the allowed group would evict a line of the other access type, and a later hit on that line would turn into a miss. Other targeted cases are an LRU that is not refreshed on hits, a disabled access type that still hits or allocates, an invalidate that misses a line filled at the same edge, and policy or enable changes made while a fill is outstanding. Each of these faults shows up at the ports as a wrong hit-or-miss latency, or as a missing or extra memory request.

// File: rtl/plru_pkg.sv
package plru_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAYS-1:0]             way_mask_t;
  typedef logic [WAYS-1:0][WAY_W-1:0]  age_vec_t;

  typedef enum logic {ST_IDLE, ST_FILL} fsm_e;

  // Ways a miss may allocate into, by policy and access type.
  function automatic way_mask_t allowed_ways(input logic [1:0] mode, input logic is_data);
    case (mode)
      2'd1:    return is_data ? 4'b1100 : 4'b0011;
      2'd2:    return is_data ? 4'b1000 : 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // Age 0 is most recent; ages younger than the touched way grow by one.
  function automatic age_vec_t touch_ages(input age_vec_t ages, input logic [WAY_W-1:0] way);
    age_vec_t r;
    r = ages;
    for (int w = 0; w < WAYS; w++) begin
      if (ages[w] < ages[way]) r[w] = ages[w] + 2'd1;
    end
    r[way] = '0;
    return r;
  endfunction

  // Invalid allowed way (lowest first), else the oldest allowed way.
  function automatic logic [WAY_W-1:0] pick_victim(input way_mask_t valid,
                                                   input age_vec_t  ages,
                                                   input way_mask_t allow);
    logic             found;
    logic [WAY_W-1:0] v;
    logic [WAY_W-1:0] best;
    found = 1'b0;
    v     = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && allow[w] && !valid[w]) begin
        found = 1'b1;
        v     = WAY_W'(w);
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (allow[w] && (!found || ages[w] > best)) begin
          found = 1'b1;
          v     = WAY_W'(w);
          best  = ages[w];
        end
      end
    end
    return v;
  endfunction

  function automatic logic [WAY_W-1:0] onehot_index(input way_mask_t oh);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (oh[w]) idx = idx | WAY_W'(w);
    end
    return idx;
  endfunction

endpackage

// File: rtl/plru_tag_store.sv
module plru_tag_store
  import plru_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output way_mask_t         hit_vec,
  output way_mask_t         valid_row,
  output logic [DATA_W-1:0] hit_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [SETS-1:0][WAYS-1:0] vld;
  logic [TAG_W-1:0]          tags  [SETS][WAYS];
  logic [DATA_W-1:0]         words [SETS][WAYS];

  assign valid_row = vld[rd_idx];

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = vld[rd_idx][g] && (tags[rd_idx][g] == rd_tag);
  end

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_data = hit_data | words[rd_idx][w];
    end
  end

  // Invalidate takes priority over a fill at the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vld <= '0;
    else if (clr_all)          vld <= '0;
    else if (wr_en)            vld[wr_idx][wr_way] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tags[wr_idx][wr_way]  <= wr_tag;
      words[wr_idx][wr_way] <= wr_data;
    end
  end

endmodule

// File: rtl/plru_age_store.sv
module plru_age_store
  import plru_pkg::*;
#(
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output age_vec_t         age_row,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way
);

  age_vec_t ages [SETS];

  assign age_row = ages[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) ages[s][w] <= WAY_W'(w);
      end
    end else if (upd_en) begin
      ages[upd_idx] <= touch_ages(ages[upd_idx], upd_way);
    end
  end

endmodule

// File: rtl/plru_victim.sv
module plru_victim
  import plru_pkg::*;
(
  input  way_mask_t        valid_row,
  input  age_vec_t         age_row,
  input  logic [1:0]       mode,
  input  logic             is_data,
  output way_mask_t        allow,
  output logic [WAY_W-1:0] victim
);

  assign allow  = allowed_ways(mode, is_data);
  assign victim = pick_victim(valid_row, age_row, allow);

endmodule

// File: rtl/plru_rd_cache.sv
module plru_rd_cache
  import plru_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int SETS    = 8,
  parameter int MEM_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              stall,
  input  logic [1:0]        mode,
  input  logic              ifetch_en,
  input  logic              data_en,
  input  logic              inv,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e              st;
  logic [ADDR_W-1:0] held_addr;
  logic              held_is_data;
  logic [1:0]        held_mode;
  logic              held_alloc;

  logic              waiting;
  logic              req_en;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  way_mask_t         hit_vec;
  way_mask_t         valid_row;
  way_mask_t         allow_mask;
  logic [DATA_W-1:0] hit_data;
  age_vec_t          age_row;
  logic [WAY_W-1:0]  victim_way;
  logic [WAY_W-1:0]  hit_way;

  // Named events for the checker
  logic hit_evt, miss_evt, fill_done, fill_evt, upd_en;

  assign waiting  = (st == ST_FILL);
  assign req_en   = req_is_data ? data_en : ifetch_en;
  assign look_idx = waiting ? held_addr[IDX_W-1:0]      : req_addr[IDX_W-1:0];
  assign look_tag = waiting ? held_addr[ADDR_W-1:IDX_W] : req_addr[ADDR_W-1:IDX_W];
  assign hit_way  = onehot_index(hit_vec);

  assign hit_evt   = !waiting && req_valid && req_en && (|hit_vec);
  assign miss_evt  = !waiting && req_valid && !(req_en && (|hit_vec));
  assign fill_done = waiting && mem_valid;
  assign fill_evt  = fill_done && held_alloc;
  assign upd_en    = hit_evt || fill_evt;

  assign rsp_valid = hit_evt || fill_done;
  assign rsp_data  = hit_evt ? hit_data : mem_data;
  assign stall     = miss_evt || (waiting && !mem_valid);
  assign mem_req   = miss_evt;
  assign mem_addr  = req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      held_addr    <= '0;
      held_is_data <= 1'b0;
      held_mode    <= '0;
      held_alloc   <= 1'b0;
    end else if (miss_evt) begin
      st           <= ST_FILL;
      held_addr    <= req_addr;
      held_is_data <= req_is_data;
      held_mode    <= mode;
      held_alloc   <= req_en;
    end else if (fill_done) begin
      st           <= ST_IDLE;
    end
  end

  plru_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (inv),
    .rd_idx    (look_idx),
    .rd_tag    (look_tag),
    .hit_vec   (hit_vec),
    .valid_row (valid_row),
    .hit_data  (hit_data),
    .wr_en     (fill_evt),
    .wr_idx    (held_addr[IDX_W-1:0]),
    .wr_way    (victim_way),
    .wr_tag    (held_addr[ADDR_W-1:IDX_W]),
    .wr_data   (mem_data)
  );

  plru_age_store #(.SETS(SETS)) u_ages (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (look_idx),
    .age_row (age_row),
    .upd_en  (upd_en),
    .upd_idx (hit_evt ? req_addr[IDX_W-1:0] : held_addr[IDX_W-1:0]),
    .upd_way (hit_evt ? hit_way : victim_way)
  );

  plru_victim u_victim (
    .valid_row (valid_row),
    .age_row   (age_row),
    .mode      (held_mode),
    .is_data   (held_is_data),
    .allow     (allow_mask),
    .victim    (victim_way)
  );

endmodule

// File: rtl/plru_rd_cache_chk.sv
module plru_rd_cache_chk
  import plru_pkg::*;
#(
  parameter int MEM_LAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_valid,
  input logic             stall,
  input logic             mem_req,
  input logic             mem_valid,
  input logic             inv,
  input logic             waiting,
  input logic             hit_evt,
  input logic             fill_evt,
  input way_mask_t        hit_vec,
  input logic [WAY_W-1:0] victim_way,
  input logic [1:0]       held_mode,
  input logic             held_is_data
);

  int unsigned lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_cnt <= 0;
    else if (waiting) lat_cnt <= lat_cnt + 1;
    else              lat_cnt <= 0;
  end

  // R1
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> (rsp_valid && !stall && !mem_req));

  // R2
  rsp_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && stall));

  // R2
  miss_enters_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (waiting && !mem_req));

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (lat_cnt < MEM_LAT));

  // R4
  victim_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |-> (((way_mask_t'(1) << victim_way) & ~allowed_ways(held_mode, held_is_data)) == '0));

  // R6
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> !hit_evt);

endmodule

bind plru_rd_cache plru_rd_cache_chk #(.MEM_LAT(MEM_LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rsp_valid    (rsp_valid),
  .stall        (stall),
  .mem_req      (mem_req),
  .mem_valid    (mem_valid),
  .inv          (inv),
  .waiting      (waiting),
  .hit_evt      (hit_evt),
  .fill_evt     (fill_evt),
  .hit_vec      (hit_vec),
  .victim_way   (victim_way),
  .held_mode    (held_mode),
  .held_is_data (held_is_data)
);

// File: tb/sim_plru_rd_cache.sv
module sim_plru_rd_cache;

  localparam int AW   = 16;
  localparam int DW   = 32;
  localparam int NS   = 8;
  localparam int LAT  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_is_data = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          stall;
  logic [1:0]    mode = 2'd0;
  logic          ifetch_en = 1'b1;
  logic          data_en = 1'b1;
  logic          inv = 1'b0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid;
  logic [DW-1:0] mem_data;

  always #4 clk = ~clk;  // 125 MHz

  plru_rd_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .MEM_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_data(req_is_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .stall(stall), .mode(mode), .ifetch_en(ifetch_en), .data_en(data_en),
    .inv(inv), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  // Backing memory with fixed latency
  int          mcnt;
  logic [AW-1:0] maddr_q;
  always @(posedge clk) begin
    if (!rst_n) mcnt <= 0;
    else if (mem_req) begin mcnt <= LAT; maddr_q <= mem_addr; end
    else if (mcnt != 0) mcnt <= mcnt - 1;
  end
  assign mem_valid = (mcnt == 1);
  assign mem_data  = mem_word(maddr_q);

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R9";
  bit    finished = 0;

  task automatic cmp(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // Reference model: validity/tag table and a recency list per set (MRU first)
  bit  mv  [NS][4];
  int  mt  [NS][4];
  int  lst [NS][4];
  bit  m_wait = 0;
  int  m_addr, m_mode;
  bit  m_isd, m_alloc;

  function automatic void touch(input int s, input int w);
    int p = 0;
    for (int i = 0; i < 4; i++) if (lst[s][i] == w) p = i;
    for (int i = p; i > 0; i--) lst[s][i] = lst[s][i-1];
    lst[s][0] = w;
  endfunction

  function automatic bit may_use(input int md, input bit isd, input int w);
    if (md == 1) return isd ? (w >= 2) : (w <= 1);
    if (md == 2) return isd ? (w == 3) : (w <= 2);
    return 1;
  endfunction

  function automatic void model_fill();
    int s = m_addr % NS;
    int v = -1;
    for (int w = 0; w < 4; w++) if (v < 0 && may_use(m_mode, m_isd, w) && !mv[s][w]) v = w;
    for (int i = 3; i >= 0; i--) if (v < 0 && may_use(m_mode, m_isd, lst[s][i])) v = lst[s][i];
    mv[s][v] = 1;
    mt[s][v] = m_addr / NS;
    touch(s, v);
  endfunction

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = 0; lst[s][w] = w; end
  end

  always begin
    bit e_rsp, e_stall, e_mreq, en, hit;
    logic [DW-1:0] e_data;
    int s, hw;
    @(negedge clk); #3;
    if (rst_n && !finished) begin
      e_rsp = 0; e_stall = 0; e_mreq = 0; e_data = '0; hw = 0;
      if (!m_wait) begin
        if (req_valid) begin
          s   = int'(req_addr) % NS;
          en  = req_is_data ? data_en : ifetch_en;
          hit = 0;
          for (int w = 0; w < 4; w++)
            if (mv[s][w] && mt[s][w] == int'(req_addr) / NS) begin hit = 1; hw = w; end
          if (en && hit) begin
            e_rsp = 1; e_data = mem_word(req_addr); touch(s, hw);
          end else begin
            e_stall = 1; e_mreq = 1; m_wait = 1; m_addr = int'(req_addr);
            m_isd = req_is_data; m_mode = int'(mode); m_alloc = en;
          end
        end
      end else if (mem_valid) begin
        e_rsp = 1; e_data = mem_word(AW'(m_addr)); m_wait = 0;
        if (m_alloc) model_fill();
      end else begin
        e_stall = 1;
      end
      if (inv) for (int s2 = 0; s2 < NS; s2++) for (int w = 0; w < 4; w++) mv[s2][w] = 0;
      cmp("rsp_valid", DW'(rsp_valid), DW'(e_rsp));
      cmp("stall", DW'(stall), DW'(e_stall));
      cmp("mem_req", DW'(mem_req), DW'(e_mreq));
      if (e_mreq) cmp("mem_addr", DW'(mem_addr), DW'(req_addr));
      if (e_rsp)  cmp("rsp_data", rsp_data, e_data);
    end
  end

  function automatic logic [AW-1:0] A(input int set, input int tag);
    return AW'(tag * NS + set);
  endfunction

  // exph: 1 expect hit, 0 expect miss, -1 no check
  task automatic access_tw(input logic [AW-1:0] a, input bit isd, input int exph,
                           input logic [1:0] nm, input bit nie, input bit nde);
    logic [1:0] om; bit oi, od; int waits;
    om = mode; oi = ifetch_en; od = data_en;
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_is_data = isd;
    waits = 0;
    forever begin
      @(negedge clk); #2;
      if (rsp_valid) break;
      waits++;
      @(posedge clk); #1;
      mode = nm; ifetch_en = nie; data_en = nde;
    end
    @(posedge clk); #1;
    req_valid = 0; mode = om; ifetch_en = oi; data_en = od;
    if (exph >= 0) cmp("hit", DW'(waits == 0), DW'(exph));
  endtask

  task automatic access(input logic [AW-1:0] a, input bit isd, input int exph);
    access_tw(a, isd, exph, mode, ifetch_en, data_en);
  endtask

  task automatic pulse_inv();
    @(posedge clk); #1; inv = 1;
    @(posedge clk); #1; inv = 0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state
    @(negedge clk); #2;
    phase = "R9";
    cmp("rsp_valid", DW'(rsp_valid), 0);
    cmp("stall", DW'(stall), 0);
    cmp("mem_req", DW'(mem_req), 0);

    phase = "R2"; access(A(0,1), 0, 0);
    phase = "R1"; access(A(0,1), 0, 1); access(A(0,1), 1, 1);

    phase = "R3";
    for (int t = 1; t <= 4; t++) access(A(1,t), 0, 0);
    access(A(1,1), 0, 1); access(A(1,2), 0, 1);
    access(A(1,5), 0, 0);
    access(A(1,1), 0, 1); access(A(1,2), 0, 1); access(A(1,4), 0, 1); access(A(1,5), 0, 1);
    phase = "R7";
    access(A(1,3), 0, 0); access(A(1,1), 0, 0); access(A(1,2), 0, 0); access(A(1,5), 0, 1);

    phase = "R10";
    pulse_inv();
    access(A(1,5), 0, 0); access(A(0,1), 1, 0);

    phase = "R4";
    @(posedge clk); #1 mode = 2'd1;
    access(A(2,1), 0, 0); access(A(2,2), 0, 0); access(A(2,3), 0, 0);
    access(A(2,10), 1, 0); access(A(2,11), 1, 0); access(A(2,12), 1, 0);
    access(A(2,2), 0, 1); access(A(2,3), 0, 1); access(A(2,11), 1, 1); access(A(2,12), 1, 1);
    phase = "R6"; access(A(2,3), 1, 1);
    phase = "R4"; access(A(2,1), 0, 0); access(A(2,11), 1, 1); access(A(2,2), 0, 0);

    phase = "R5";
    @(posedge clk); #1 mode = 2'd2;
    access(A(3,1), 1, 0); access(A(3,2), 1, 0); access(A(3,3), 1, 0);
    access(A(3,1), 1, 0); access(A(3,1), 1, 1);
    access(A(3,5), 0, 0); access(A(3,6), 0, 0); access(A(3,7), 0, 0);
    access(A(3,5), 0, 1); access(A(3,8), 0, 0); access(A(3,6), 0, 0);
    access(A(3,5), 0, 1); access(A(3,1), 1, 1);
    phase = "R6";
    @(posedge clk); #1 mode = 2'd0;
    access(A(3,1), 0, 1); access(A(3,8), 1, 1);

    phase = "R8";
    @(posedge clk); #1 data_en = 0;
    access(A(4,1), 1, 0); access(A(4,1), 1, 0);
    access(A(4,2), 0, 0); access(A(4,2), 0, 1);
    @(posedge clk); #1 data_en = 1;
    access(A(4,3), 1, 0); access(A(4,3), 1, 1);
    @(posedge clk); #1 data_en = 0;
    access(A(4,3), 1, 0); access(A(4,3), 0, 1);
    @(posedge clk); #1 data_en = 1; ifetch_en = 0;
    access(A(4,2), 0, 0);
    @(posedge clk); #1 ifetch_en = 1;
    access(A(4,2), 0, 1);

    phase = "R11";
    access_tw(A(5,1), 0, 0, 2'd0, 1'b0, 1'b1);
    access(A(5,1), 0, 1);
    @(posedge clk); #1 data_en = 0;
    access_tw(A(5,2), 1, 0, 2'd0, 1'b1, 1'b1);
    @(posedge clk); #1 data_en = 1;
    access(A(5,2), 1, 0);
    @(posedge clk); #1 mode = 2'd2;
    access(A(6,1), 1, 0);
    access_tw(A(6,2), 1, 0, 2'd0, 1'b1, 1'b1);
    @(posedge clk); #1 mode = 2'd0;
    access(A(6,1), 1, 0);

    phase = "R7";
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      mode = 2'($urandom % 4);
      ifetch_en = ($urandom % 8) != 0;
      data_en   = ($urandom % 8) != 0;
      if ($urandom % 20 == 0) pulse_inv();
      access(A($urandom % 2, $urandom % 6), 1'($urandom % 2), -1);
    end

    repeat (4) @(posedge clk);
    finished = 1;
    report();
    $finish;
  end

endmodule